// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one transfer at a time on a 16-bit bus where address and data share the same wires. A requester presents an access kind, a 20-bit byte address, a size (byte or word) and write data for one clock while the sequencer is idle. The sequencer then steps through the address state, the turnaround state, the data state, any wait states and the closing state. It drives the address latch pulse, the read, write and interrupt-acknowledge strobes, the transceiver enable and direction, the memory/IO select, the high-byte enable and the output enable of the shared bus.

For a read, the returned bytes are packed into a 16-bit result. A word whose address is odd cannot be moved in one transfer. The block splits it into two byte transfers without help from the requester. The low byte moves first, on the upper lane at the odd address. The high byte moves second, on the lower lane at the next address. Only one completion pulse is given for the pair. The transceiver enable has edges in the middle of a clock, and these come from a register on the falling clock edge, so the block still needs only one clock input.

Top module: `mux_bus_seq`

## Requirements
- R1: While the block is in reset or idle, the latch pulse is low. The read, write and acknowledge strobes and the transceiver enable (all active low) are high. The bus output enable is low, and busy and done are low.
- R2: A request seen at a rising edge while the block is idle puts the block in the address state for the following clock. In that clock only, the latch pulse is high. One transfer lasts four clocks plus any wait clocks. done_o is high for exactly the one closing clock of the final transfer, and the next clock is idle.
- R3: If ready_i is low at the end of the data state or of a wait state, one more wait clock is added, and the active strobe stays low through it.
- R4: The kind codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write and 4 interrupt acknowledge. Read kinds pull rd_no low, write kinds pull wr_no low and kind 4 pulls inta_no low. Each strobe is low only in the turnaround, data and wait states.
- R5: In the address state, ad_o carries address bits 15..0. addr_hi_o carries bits 19..16 for memory kinds and zero otherwise. The lane code is {bhe_no, ad_o[0]}: 00 for an even word, 01 for an odd byte, 10 for an even byte, and never 11.
- R6: A word at an odd address runs as two transfers back to back. The first is at the address with code 01. The second is at address+1, with the carry reaching bit 16 and above, and with code 10. done_o is low after the first transfer.
- R7: For writes, den_no is low from the start of the turnaround state to the middle of the closing state. For reads and acknowledges, it is low from the middle of the turnaround state to the middle of the closing state.
- R8: mio_o is 1 for memory kinds and dtr_o is 1 for write kinds. Both are set when a request is taken and hold steady through the closing state.
- R9: The bus output enable is high in the address state, except for acknowledges, where it stays low for the whole transfer. For reads it drops from the turnaround state on. For writes it stays high to the closing state, with the data byte on the lane chosen by the lane code, or the full word for an even word.
- R10: Read data is taken from ad_i at the edge that leaves the data or last wait state. For an even word it is ad_i as is. For a byte it is the selected lane, zero-extended. For an odd word it is the upper lane of the first transfer as the low byte and the lower lane of the second transfer as the high byte. It is valid while done_o is high.
- R11: A request that arrives while busy_o is high is ignored: no further transfer starts.
- R12: Pulling rst_ni low in the middle of a transfer returns every output to its idle value at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_kind_i | input | 3 | Access kind code |
| req_addr_i | input | 20 | Byte address |
| req_word_i | input | 1 | 1 for a word, 0 for a byte |
| req_wdata_i | input | 16 | Write data, low byte for byte writes |
| ready_i | input | 1 | Device ready, sampled in data and wait states |
| ad_i | input | 16 | Shared bus input |
| ad_o | output | 16 | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| addr_hi_o | output | 4 | Upper address bits in the address state |
| ale_o | output | 1 | Address latch pulse |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| den_no | output | 1 | Transceiver enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| bhe_no | output | 1 | High byte enable, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Request complete pulse |
| rdata_o | output | 16 | Read result |

## Verification
The latch pulse shows in the clock after the edge that takes the request. The strobes follow one clock later. The closing state, done_o and rdata_o come three clocks after the latch pulse plus one clock per wait, and the next clock is idle. Every clock-level output is sampled 1 ns after a rising edge. The transceiver enable is sampled a second time 3.5 ns after the rising edge, which is past the falling edge, to see the edges in the middle of the turnaround and closing states. The bench drives ready_i low for the exact number of wait clocks it asks for and releases it in the last one. It then counts clocks from the latch pulse to the closing state, so that an added or missing clock shifts every later check.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {ST_TI, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4} tstate_e;
  typedef enum logic [2:0] {
    K_MEM_RD = 3'd0, K_MEM_WR = 3'd1, K_IO_RD = 3'd2, K_IO_WR = 3'd3, K_INTA = 3'd4
  } kind_e;
endpackage

// File: rtl/mbs_tstate.sv
module mbs_tstate
  import mbs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    split_i,
  input  logic    ready_i,
  output tstate_e state_o,
  output logic    phase_o,
  output logic    cap_o,
  output logic    done_o
);
  tstate_e st_q, st_d;
  logic    phase_q;
  logic    more;

  assign more = split_i && !phase_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_TI:        st_d = start_i ? ST_T1 : ST_TI;
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:        st_d = more ? ST_T1 : ST_TI;
      default:      st_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_TI;
      phase_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_i && st_q == ST_TI) phase_q <= 1'b0;
      else if (st_q == ST_T4 && more) phase_q <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign phase_o = phase_q;
  assign cap_o   = (st_q == ST_T3 || st_q == ST_TW) && ready_i;
  assign done_o  = (st_q == ST_T4) && !more;
endmodule

// File: rtl/mbs_lane.sv
module mbs_lane #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          word_i,
  input  logic          phase_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ad_i,
  input  logic          cap_i,
  output logic          split_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          bhe_no,
  output logic [DW-1:0] lane_data_o,
  output logic [DW-1:0] rdata_o
);
  localparam int HB = DW / 2;

  logic          full;
  logic [HB-1:0] wbyte;
  logic [DW-1:0] rdata_q;

  assign split_o    = word_i && base_i[0];
  assign full       = word_i && !base_i[0];
  assign cur_addr_o = base_i + AW'(phase_i);
  assign bhe_no     = full ? 1'b0 : !cur_addr_o[0];
  assign wbyte      = (split_o && phase_i) ? wdata_i[DW-1:HB] : wdata_i[HB-1:0];

  always_comb begin
    if (full)               lane_data_o = wdata_i;
    else if (cur_addr_o[0]) lane_data_o = {wbyte, {HB{1'b0}}};
    else                    lane_data_o = {{HB{1'b0}}, wbyte};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cap_i) begin
      if (full)         rdata_q <= ad_i;
      else if (split_o) begin
        if (phase_i) rdata_q[DW-1:HB] <= ad_i[HB-1:0];
        else         rdata_q[HB-1:0]  <= ad_i[DW-1:HB];
      end else
        rdata_q <= {{HB{1'b0}}, cur_addr_o[0] ? ad_i[DW-1:HB] : ad_i[HB-1:0]};
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbs_den.sv
module mbs_den (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic window_i,
  input  logic early_i,
  output logic den_no
);
  logic late_q;

  // falling-edge register gives the mid-clock edges
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) late_q <= 1'b0;
    else         late_q <= window_i;
  end

  assign den_no = !(late_q || early_i);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_kind_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             req_word_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             ready_i,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             inta_no,
  output logic             den_no,
  output logic             dtr_o,
  output logic             mio_o,
  output logic             bhe_no,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int HW = AW - DW;

  tstate_e       st;
  logic          phase, cap, split, start, lane_bhe_n;
  kind_e         kind_q, kind_in;
  logic [AW-1:0] addr_q, cur_addr;
  logic          word_q, mio_q, dtr_q;
  logic [DW-1:0] wdata_q, lane_data;
  logic          is_rd, is_wr, is_ia, is_mem, win, late_win;

  assign kind_in = kind_e'(req_kind_i);
  assign start   = req_valid_i && (st == ST_TI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_MEM_RD;
      addr_q  <= '0;
      word_q  <= 1'b0;
      wdata_q <= '0;
      mio_q   <= 1'b0;
      dtr_q   <= 1'b0;
    end else if (start) begin
      kind_q  <= kind_in;
      addr_q  <= req_addr_i;
      word_q  <= req_word_i;
      wdata_q <= req_wdata_i;
      mio_q   <= (kind_in == K_MEM_RD) || (kind_in == K_MEM_WR);
      dtr_q   <= (kind_in == K_MEM_WR) || (kind_in == K_IO_WR);
    end
  end

  mbs_tstate u_tstate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .split_i (split),
    .ready_i (ready_i),
    .state_o (st),
    .phase_o (phase),
    .cap_o   (cap),
    .done_o  (done_o)
  );

  mbs_lane #(.AW(AW), .DW(DW)) u_lane (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (addr_q),
    .word_i      (word_q),
    .phase_i     (phase),
    .wdata_i     (wdata_q),
    .ad_i        (ad_i),
    .cap_i       (cap),
    .split_o     (split),
    .cur_addr_o  (cur_addr),
    .bhe_no      (lane_bhe_n),
    .lane_data_o (lane_data),
    .rdata_o     (rdata_o)
  );

  assign is_rd    = (kind_q == K_MEM_RD) || (kind_q == K_IO_RD);
  assign is_wr    = (kind_q == K_MEM_WR) || (kind_q == K_IO_WR);
  assign is_ia    = (kind_q == K_INTA);
  assign is_mem   = (kind_q == K_MEM_RD) || (kind_q == K_MEM_WR);
  assign win      = (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  assign late_win = win && (is_rd || is_wr || is_ia);

  mbs_den u_den (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .window_i (late_win),
    .early_i  (is_wr && st == ST_T2),
    .den_no   (den_no)
  );

  assign busy_o    = (st != ST_TI);
  assign ale_o     = (st == ST_T1);
  assign rd_no     = !(win && is_rd);
  assign wr_no     = !(win && is_wr);
  assign inta_no   = !(win && is_ia);
  assign ad_oe_o   = (ale_o && !is_ia) || (is_wr && (win || st == ST_T4));
  assign ad_o      = ale_o ? cur_addr[DW-1:0] : (is_wr ? lane_data : '0);
  assign addr_hi_o = (ale_o && is_mem) ? cur_addr[AW-1:DW] : {HW{1'b0}};
  assign bhe_no    = busy_o ? lane_bhe_n : 1'b1;
  assign mio_o     = mio_q;
  assign dtr_o     = dtr_q;
endmodule

// File: rtl/mbs_checks.sv
module mbs_checks #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_i,
  input logic          ale_o,
  input logic          rd_no,
  input logic          wr_no,
  input logic          inta_no,
  input logic          den_no,
  input logic          bhe_no,
  input logic [DW-1:0] ad_o,
  input logic          ad_oe_o,
  input logic          mio_o,
  input logic          dtr_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r2_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r3_wait_holds_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && !ready_i) |=> !rd_no);
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!rd_no, !wr_no, !inta_no}) <= 1);
  a_r4_quiet_in_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> rd_no && wr_no && inta_no);
  a_r5_lane_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !(bhe_no && ad_o[0]));
  a_r7_den_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> den_no);
  a_r8_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ale_o) |-> $stable(mio_o) && $stable(dtr_o));
  a_r9_read_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);
endmodule

bind mux_bus_seq mbs_checks #(.DW(DW)) u_chk (.*);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        ready = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out, rdata;
  logic [3:0]  addr_hi;
  logic ad_oe, ale, rd_n, wr_n, inta_n, den_n, dtr, mio, bhe_n, busy, done;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_word_i(req_word), .req_wdata_i(req_wdata),
    .ready_i(ready), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .addr_hi_o(addr_hi), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n),
    .inta_no(inta_n), .den_no(den_n), .dtr_o(dtr), .mio_o(mio),
    .bhe_no(bhe_n), .busy_o(busy), .done_o(done), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  kind;
    logic [19:0] addr;
    logic        word;
    logic [15:0] wdata;
    logic [15:0] resp;
    logic [1:0]  waits;
    logic [15:0] exp_rd;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{3'd0, 20'h12344, 1'b1, 16'h0000, 16'hBEEF, 2'd0, 16'hBEEF},
    '{3'd1, 20'h00010, 1'b1, 16'hA55A, 16'h0000, 2'd1, 16'h0000},
    '{3'd0, 20'h00022, 1'b0, 16'h0000, 16'h1234, 2'd0, 16'h0034},
    '{3'd0, 20'h00023, 1'b0, 16'h0000, 16'h1234, 2'd0, 16'h0012},
    '{3'd1, 20'h00101, 1'b0, 16'h00C3, 16'h0000, 2'd0, 16'h0000},
    '{3'd0, 20'h00201, 1'b1, 16'h0000, 16'h5678, 2'd2, 16'h7856},
    '{3'd1, 20'h0FFFF, 1'b1, 16'h9ABC, 16'h0000, 2'd0, 16'h0000},
    '{3'd2, 20'h00060, 1'b1, 16'h0000, 16'h1357, 2'd3, 16'h1357},
    '{3'd3, 20'hA0044, 1'b0, 16'h0077, 16'h0000, 2'd0, 16'h0000},
    '{3'd4, 20'h00000, 1'b1, 16'h0000, 16'h0048, 2'd1, 16'h0048}
  };

  task automatic run_vec(input vec_t v);
    bit is_rd = (v.kind == 3'd0) || (v.kind == 3'd2);
    bit is_wr = (v.kind == 3'd1) || (v.kind == 3'd3);
    bit is_ia = (v.kind == 3'd4);
    bit is_mem = (v.kind == 3'd0) || (v.kind == 3'd1);
    bit split = v.word && v.addr[0];
    bit full = v.word && !v.addr[0];
    int nph = split ? 2 : 1;
    @(negedge clk);
    req_kind = v.kind; req_addr = v.addr; req_word = v.word; req_wdata = v.wdata;
    ad_in = v.resp; ready = (v.waits == 0); req_valid = 1'b1;
    for (int p = 0; p < nph; p++) begin
      logic [19:0] cur = v.addr + 20'(p);
      logic [7:0] eb = (split && p == 1) ? v.wdata[15:8] : v.wdata[7:0];
      @(posedge clk); #1;
      req_valid = 1'b0;
      ready = (v.waits == 0);
      chk("R2 ale in T1", ale, 1'b1);
      chk("R5 lane code", {bhe_n, ad_out[0]}, full ? 2'b00 : {~cur[0], cur[0]});
      if (!is_ia) chk("R5 addr low", ad_out, cur[15:0]);
      chk("R5 addr high", addr_hi, is_mem ? cur[19:16] : 4'h0);
      chk("R8 mio", mio, is_mem);
      chk("R8 dtr", dtr, is_wr);
      chk("R9 oe T1", ad_oe, !is_ia);
      chk("R4 strobes off T1", {rd_n, wr_n, inta_n}, 3'b111);
      @(posedge clk); #1;
      chk("R4 strobes T2", {rd_n, wr_n, inta_n}, {!is_rd, !is_wr, !is_ia});
      chk("R9 oe T2", ad_oe, is_wr);
      chk("R7 den early T2", den_n, !is_wr);
      if (is_wr) begin
        if (full)        chk("R9 word data", ad_out, v.wdata);
        else if (cur[0]) chk("R9 upper lane", ad_out[15:8], eb);
        else             chk("R9 lower lane", ad_out[7:0], eb);
      end
      #2.5;
      chk("R7 den late T2", den_n, 1'b0);
      @(posedge clk); #1;
      chk("R4 strobes T3", {rd_n, wr_n, inta_n}, {!is_rd, !is_wr, !is_ia});
      for (int w = 1; w <= v.waits; w++) begin
        @(posedge clk); #1;
        chk("R3 wait strobe", {rd_n, wr_n, inta_n}, {!is_rd, !is_wr, !is_ia});
        chk("R3 wait no done", done, 1'b0);
        if (w == v.waits) ready = 1'b1;
      end
      @(posedge clk); #1;
      chk("R4 strobes off T4", {rd_n, wr_n, inta_n}, 3'b111);
      chk("R7 den T4 first half", den_n, 1'b0);
      chk("R6 done timing", done, p == nph - 1);
      chk("R8 mio held", mio, is_mem);
      if (p == nph - 1 && !is_wr) chk("R10 read data", rdata, v.exp_rd);
      #2.5;
      chk("R7 den T4 second half", den_n, 1'b1);
    end
    @(posedge clk); #1;
    chk("R2 idle after", {busy, done, ale}, 3'b000);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ale_cnt, wr_cnt;
    #12;
    // R1 reset state
    chk("R1 reset strobes", {rd_n, wr_n, inta_n, den_n}, 4'hF);
    chk("R1 reset misc", {ale, ad_oe, busy, done}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle", {ale, ad_oe, busy, den_n, rd_n}, 5'b00011);

    for (int i = 0; i < 10; i++) run_vec(VECS[i]);

    // R11 request while busy
    @(negedge clk);
    req_kind = 3'd0; req_addr = 20'h00400; req_word = 1'b1; ready = 1'b1; req_valid = 1'b1;
    ale_cnt = 0; wr_cnt = 0;
    for (int i = 0; i < 9; i++) begin
      @(posedge clk); #1;
      if (ale) ale_cnt++;
      if (!wr_n) wr_cnt++;
      req_valid = (i == 1);
      if (i == 1) begin req_kind = 3'd1; req_addr = 20'h00800; end
    end
    chk("R11 one transfer", ale_cnt, 1);
    chk("R11 no write", wr_cnt, 0);
    chk("R11 idle", busy, 1'b0);

    // R12 reset mid transfer
    @(negedge clk);
    req_kind = 3'd1; req_addr = 20'h00900; req_valid = 1'b1;
    @(posedge clk); #1; req_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R12 writing", wr_n, 1'b0);
    rst_n = 1'b0; #0.5;
    chk("R12 strobes idle", {rd_n, wr_n, inta_n, den_n}, 4'hF);
    chk("R12 others idle", {ale, ad_oe, busy, done}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R12 stays idle", {busy, ale}, 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule